// File: doc/BRIEF.md
# Whole-Packet Receive Buffer

This block sits at the ingress of a network interface, between the network link and the engine that writes received data to memory. Flits of 64 bits arrive from the link with a valid strobe and an end-of-packet marker. The link cannot be held off, so the block takes every flit and decides internally whether to keep it. Kept flits are held in a circular store of configurable depth. A packet becomes visible to the downstream writer only once its final flit has been stored, so the writer never receives a partial packet.

When a flit arrives and the store has no free entry, the block abandons the whole packet. It rewinds the speculative write position to the last committed packet boundary and ignores the remaining flits of that packet up to and including its end marker. A counter records each abandoned packet. An occupancy output counts committed and speculative flits together, so a flow-control unit can see the buffer filling while a packet is still arriving.

The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the presented flit and its marker stay unchanged until the transfer happens. `out_valid` never depends on `out_ready`. The input has no back-pressure: a flit is present in every cycle where `in_valid` is high.

Top module: `pkt_rx_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, `occupancy` is 0 and `drop_count` is 0.
- R2: A flit accepted on a clock edge with `in_last`=1 makes its whole packet visible: `out_valid` can first show that packet's flits after that same edge. No flit of an unfinished packet is ever presented.
- R3: A flit that arrives while `occupancy` equals DEPTH is not stored. Every flit already stored for that packet is discarded, and `occupancy` falls back to the count of committed unread flits.
- R4: After a discard, every further flit of the same packet, up to and including the one with `in_last`=1, is ignored. It leaves `occupancy` and the output stream unchanged.
- R5: Delivered flits leave in arrival order with their 64-bit data and their end marker intact. `out_last`=1 appears exactly on each packet's final flit.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R7: `occupancy` equals committed-but-unread flits plus speculative flits of the packet in progress. It rises by at most one per cycle and never exceeds DEPTH.
- R8: `drop_count` rises by exactly one for each discarded packet and is otherwise unchanged. It wraps modulo 2^CNT_W.
- R9: A packet longer than DEPTH flits is always discarded, even into an empty buffer.
- R10: The first flit after the end marker of a discarded packet starts a new packet, which is stored normally if there is space.
- R11: A free entry reported by `occupancy` in a cycle is usable in that cycle. An entry freed by a transfer in the same cycle becomes usable only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present on the link side |
| in_data | input | FLIT_W | Flit payload |
| in_last | input | 1 | Flit ends its packet |
| out_valid | output | 1 | Committed flit available |
| out_ready | input | 1 | Downstream takes the flit this cycle |
| out_data | output | FLIT_W | Flit payload towards the writer |
| out_last | output | 1 | Presented flit ends its packet |
| occupancy | output | $clog2(DEPTH)+1 | Committed plus speculative flits held |
| drop_count | output | CNT_W | Discarded packets, wrapping |

## Verification
The bench builds the block with DEPTH 8, 64-bit flits and a 16-bit drop counter. An eight-entry store fills after a few short packets under a stalled reader. This brings overflow in the middle of a packet, overflow on a final flit, packets longer than the whole store and exactly-full packets within reach in a short run. Random packet lengths of up to twelve flits, random gaps and random back-pressure then mix commits, rollbacks and concurrent reads against the behavioural queue model.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef struct packed {
    logic        last;
    logic [63:0] data;
  } rxb_flit_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  rxb_pkg::rxb_flit_t wr_flit,
  input  logic [AW-1:0]     rd_addr,
  output rxb_pkg::rxb_flit_t rd_flit
);
  rxb_pkg::rxb_flit_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(g))) begin
        mem[g] <= wr_flit;
      end
    end
  end

  assign rd_flit = mem[rd_addr];
endmodule

// File: rtl/rxb_wr_ctrl.sv
module rxb_wr_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [PW-1:0]    rd_ptr,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [PW-1:0]    spec_ptr,
  output logic [PW-1:0]    commit_ptr,
  output logic [CNT_W-1:0] drop_count
);
  typedef enum logic {S_KEEP, S_DISCARD} wr_state_e;

  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  wr_state_e       state_q, state_d;
  logic [PW-1:0]   spec_d, commit_d;
  logic [CNT_W-1:0] drop_d;
  logic [PW-1:0]   level;
  logic            full;

  assign level   = spec_ptr - rd_ptr;
  assign full    = (level == FULL_LVL);
  assign wr_addr = spec_ptr[AW-1:0];

  always_comb begin
    state_d  = state_q;
    spec_d   = spec_ptr;
    commit_d = commit_ptr;
    drop_d   = drop_count;
    wr_en    = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        S_KEEP: begin
          if (full) begin
            spec_d = commit_ptr;
            drop_d = drop_count + CNT_W'(1);
            if (!in_last) state_d = S_DISCARD;
          end else begin
            wr_en  = 1'b1;
            spec_d = spec_ptr + PW'(1);
            if (in_last) commit_d = spec_ptr + PW'(1);
          end
        end
        S_DISCARD: begin
          if (in_last) state_d = S_KEEP;
        end
        default: state_d = S_KEEP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_KEEP;
      spec_ptr   <= '0;
      commit_ptr <= '0;
      drop_count <= '0;
    end else begin
      state_q    <= state_d;
      spec_ptr   <= spec_d;
      commit_ptr <= commit_d;
      drop_count <= drop_d;
    end
  end
endmodule

// File: rtl/rxb_rd_ctrl.sv
module rxb_rd_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] commit_ptr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [PW-1:0] rd_ptr,
  output logic [AW-1:0] rd_addr
);
  assign out_valid = (rd_ptr != commit_ptr);
  assign rd_addr   = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
    end else if (out_valid && out_ready) begin
      rd_ptr <= rd_ptr + PW'(1);
    end
  end
endmodule

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer #(
  parameter int FLIT_W = 64,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_last,
  output logic [PW-1:0]     occupancy,
  output logic [CNT_W-1:0]  drop_count
);
  logic               wr_en;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [PW-1:0]      spec_ptr, commit_ptr, rd_ptr;
  rxb_pkg::rxb_flit_t wr_flit, rd_flit;

  if (FLIT_W != 64 || (1 << AW) != DEPTH) begin : g_bad_cfg
    initial $error("pkt_rx_buffer: FLIT_W must be 64 and DEPTH a power of two");
  end

  assign wr_flit.data = in_data;
  assign wr_flit.last = in_last;

  rxb_wr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .spec_ptr(spec_ptr), .commit_ptr(commit_ptr), .drop_count(drop_count)
  );

  rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_flit(wr_flit),
    .rd_addr(rd_addr), .rd_flit(rd_flit)
  );

  rxb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .commit_ptr(commit_ptr), .out_ready(out_ready),
    .out_valid(out_valid), .rd_ptr(rd_ptr), .rd_addr(rd_addr)
  );

  assign out_data  = rd_flit.data;
  assign out_last  = rd_flit.last;
  assign occupancy = spec_ptr - rd_ptr;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int FLIT_W = 64,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  parameter int PW     = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_data,
  input logic              out_last,
  input logic [PW-1:0]     occupancy,
  input logic [CNT_W-1:0]  drop_count
);
  // R7: never above capacity
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);

  // R7: grows by at most one flit per cycle
  a_r7_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(occupancy) <= int'($past(occupancy)) + 1);

  // R6: held output under back-pressure
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: counter moves by zero or one
  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count == $past(drop_count)) ||
             (drop_count == $past(drop_count) + CNT_W'(1)));

  // R2: nothing presented from an empty buffer
  a_r2_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !out_valid);
endmodule

bind pkt_rx_buffer rxb_checker #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .occupancy(occupancy),
  .drop_count(drop_count)
);

// File: tb/pkt_rx_buffer_bench.sv
module pkt_rx_buffer_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = 16;
  localparam int PW     = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic out_valid, out_last;
  logic [63:0] out_data;
  logic [PW-1:0] occupancy;
  logic [CNT_W-1:0] drop_count;

  always #(PERIOD/2) clk = ~clk;

  pkt_rx_buffer #(.FLIT_W(64), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_pkt_rx_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .occupancy(occupancy),
    .drop_count(drop_count)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [64:0] committed[$];
  logic [64:0] pending[$];
  bit discarding = 0;
  int drops = 0;
  logic [63:0] seq = 64'h1000;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ev = committed.size() > 0;
    chk(out_valid == ev, "R2 out_valid", 64'(out_valid), 64'(ev));
    if (ev) begin
      chk(out_data == committed[0][63:0], "R5 out_data", out_data, committed[0][63:0]);
      chk(out_last == committed[0][64], "R5 out_last", 64'(out_last), 64'(committed[0][64]));
    end
    chk(int'(occupancy) == committed.size() + pending.size(), "R7 occupancy",
        64'(occupancy), 64'(committed.size() + pending.size()));
    chk(drop_count == CNT_W'(drops), "R8 drop_count", 64'(drop_count), 64'(CNT_W'(drops)));
  endtask

  // one cycle: compare, drive, advance model (R3 R4 R9 R10 R11)
  task automatic step(bit v, logic [63:0] d, bit l, bit r);
    int occ;
    compare();
    in_valid = v; in_data = d; in_last = l; out_ready = r;
    occ = committed.size() + pending.size();
    if (r && committed.size() > 0) void'(committed.pop_front());
    if (v) begin
      if (discarding) begin
        if (l) discarding = 0;
      end else if (occ >= DEPTH) begin
        pending.delete();
        drops++;
        if (!l) discarding = 1;
      end else begin
        pending.push_back({l, d});
        if (l) begin
          foreach (pending[i]) committed.push_back(pending[i]);
          pending.delete();
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic send_pkt(int len, int ready_pct);
    for (int i = 0; i < len; i++) begin
      seq = seq + 64'h1_0001;
      step(1'b1, seq, i == len - 1, $urandom_range(0, 99) < ready_pct);
    end
  endtask

  task automatic idle(int n, bit r);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
    chk(occupancy == 0, "R1 occupancy", 64'(occupancy), 0);
    chk(drop_count == 0, "R1 drop_count", 64'(drop_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R5: single packets, reader always ready
    send_pkt(3, 100); idle(4, 1);
    send_pkt(1, 100); idle(3, 1);
    // R6: stalled reader, then drain
    send_pkt(2, 0); idle(3, 0); idle(4, 1);
    // R3: fill with stalled reader, overflow mid-packet, R4 tail discarded
    send_pkt(5, 0); send_pkt(6, 0); idle(2, 0);
    // R10: next packet accepted after drain
    idle(8, 1); send_pkt(2, 0); idle(3, 1);
    // exactly-full packet, then overflow on a final flit (R3)
    send_pkt(8, 0); send_pkt(1, 0); idle(2, 0); idle(10, 1);
    // R9: oversize packet into empty buffer
    send_pkt(11, 100); idle(3, 1);
    // R11: full buffer, read and write in the same cycle
    send_pkt(8, 0); send_pkt(2, 100); idle(10, 1);
    // mixed random traffic
    for (int p = 0; p < 400; p++) begin
      send_pkt($urandom_range(1, 12), $urandom_range(0, 100));
      idle($urandom_range(0, 3), $urandom_range(0, 1));
    end
    idle(30, 1);
    finish_run();
  end
endmodule